// File: doc/BRIEF.md
# Periodic BCD Alarm Comparator

This block holds four byte-wide alarm registers (seconds, minutes, hours and day-of-month, all BCD) and compares them with a BCD time-of-day supplied from outside. The comparison is made only on cycles where a one-second strobe is high. When the enabled fields agree, and the single interrupt enable input is high, the block emits an interrupt pulse one clock wide.

Bit 7 of every alarm register is a "don't care" flag for its field. The combination of flags sets how often the alarm repeats: monthly, daily, hourly, once a minute or every second. Software reaches the registers through a plain byte port: a write strobe with a 2-bit register select and data, and a read path that returns the selected register without delay. Writes whose BCD value is out of range for the field are dropped, and the register keeps its old value.

Top module: `bcd_alarm_unit`

## Requirements
- R1: After reset, all four alarm registers read 0x00 and the interrupt output is low.
- R2: Register select values are 0 = seconds, 1 = minutes, 2 = hours, 3 = date. An accepted write stores all 8 bits, bit 7 included, and a read returns that byte in the same cycle.
- R3: The field value is computed as (upper nibble × 10) + lower nibble, on the bits named in R4 to R6. A nibble above 9 is not rejected on its own.
- R4: A write to seconds or minutes is accepted only if the value computed over bits 6:0 is at most 59.
- R5: A write to hours is accepted only if the value computed over bits 5:0 is at most 23.
- R6: A write to date is rejected when the value computed over bits 4:0 is zero. For example, 0x20 is rejected. Any other value is accepted.
- R7: With no bit-7 flags set, the alarm fires on a tick when seconds (bits 6:0), minutes (6:0), hours (5:0) and date (5:0) all equal the time inputs.
- R8: With only the date flag set, hours, minutes and seconds must match. With the date and hour flags set, minutes and seconds must match. With the date, hour and minute flags set, only seconds must match.
- R9: Any other flag pattern, including all four set or only the seconds flag set, fires on every tick.
- R10: The interrupt goes high exactly one cycle after the tick edge that produced a match, for one cycle only. The compare uses the register contents from before any write made on that same edge.
- R11: While the interrupt enable input is low, no interrupt pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 sec, 1 min, 2 hour, 3 date) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Contents of the selected register |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| irq_en | input | 1 | Interrupt enable |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| alarm_irq | output | 1 | Alarm interrupt pulse |

## Verification
Register contents show on rd_data in the same cycle, as soon as the write edge has passed. The bench therefore reads back at the falling edge that follows the write. An alarm pulse is due one register stage after the edge that samples the tick. A behavioural model in the bench works out the expected pulse at every rising edge, using the register values from before that edge's write, and compares it with the output at each falling edge. Directed scenarios also check the pulse at the falling edge right after each tick, so each flag pattern, each rejected write and the enable gating all have checks tied to their own requirement.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int NFIELD  = 4;
    localparam int BYTE_W  = 8;
    localparam int SEL_W   = $clog2(NFIELD);

    localparam int FLD_SEC  = 0;
    localparam int FLD_MIN  = 1;
    localparam int FLD_HOUR = 2;
    localparam int FLD_DATE = 3;

    typedef enum logic [2:0] {
        RATE_MONTH,
        RATE_DAY,
        RATE_HOUR,
        RATE_MINUTE,
        RATE_SECOND
    } rate_e;

    typedef logic [NFIELD-1:0][BYTE_W-1:0] field_arr_t;

    // Bits of each field that take part in range checks
    function automatic logic [BYTE_W-1:0] check_bits(input int fld);
        case (fld)
            FLD_SEC, FLD_MIN: return 8'h7F;
            FLD_HOUR:         return 8'h3F;
            default:          return 8'h1F;
        endcase
    endfunction

    // Bits of each field that take part in the time compare
    function automatic logic [BYTE_W-1:0] cmp_bits(input int fld);
        case (fld)
            FLD_SEC, FLD_MIN: return 8'h7F;
            default:          return 8'h3F;
        endcase
    endfunction

    // Decimal weight of a two-digit BCD byte, nibbles taken as-is
    function automatic logic [7:0] bcd_weight(input logic [BYTE_W-1:0] v);
        logic [7:0] hi;
        logic [7:0] lo;
        hi = {4'd0, v[7:4]};
        lo = {4'd0, v[3:0]};
        return (hi << 3) + (hi << 1) + lo;
    endfunction
endpackage

// File: rtl/alarm_field_check.sv
module alarm_field_check
    import alarm_pkg::*;
#(
    parameter int FIELD = FLD_SEC
) (
    input  logic [BYTE_W-1:0] value_i,
    output logic              ok_o
);
    localparam logic [BYTE_W-1:0] CHK = check_bits(FIELD);

    logic [7:0] weight_d;

    always_comb begin
        weight_d = bcd_weight(value_i & CHK);
    end

    generate
        if (FIELD == FLD_SEC || FIELD == FLD_MIN) begin : g_sixty
            assign ok_o = (weight_d <= 8'd59);
        end else if (FIELD == FLD_HOUR) begin : g_hours
            assign ok_o = (weight_d <= 8'd23);
        end else begin : g_date
            assign ok_o = (weight_d != 8'd0);
        end
    endgenerate
endmodule

// File: rtl/alarm_rate_decode.sv
module alarm_rate_decode
    import alarm_pkg::*;
(
    input  logic [NFIELD-1:0] flag_i,
    output rate_e             rate_o
);
    always_comb begin
        case (flag_i)
            4'b0000: rate_o = RATE_MONTH;
            4'b1000: rate_o = RATE_DAY;
            4'b1100: rate_o = RATE_HOUR;
            4'b1110: rate_o = RATE_MINUTE;
            default: rate_o = RATE_SECOND;
        endcase
    end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_pkg::*;
(
    input  field_arr_t alarm_i,
    input  field_arr_t now_i,
    input  rate_e      rate_i,
    output logic       hit_o
);
    logic [NFIELD-1:0] eq_d;

    genvar gi;
    generate
        for (gi = 0; gi < NFIELD; gi++) begin : g_eq
            localparam logic [BYTE_W-1:0] CM = cmp_bits(gi);
            assign eq_d[gi] = ((alarm_i[gi] & CM) == (now_i[gi] & CM));
        end
    endgenerate

    always_comb begin
        case (rate_i)
            RATE_MONTH:  hit_o = &eq_d;
            RATE_DAY:    hit_o = eq_d[FLD_HOUR] & eq_d[FLD_MIN] & eq_d[FLD_SEC];
            RATE_HOUR:   hit_o = eq_d[FLD_MIN] & eq_d[FLD_SEC];
            RATE_MINUTE: hit_o = eq_d[FLD_SEC];
            default:     hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/bcd_alarm_unit.sv
module bcd_alarm_unit
    import alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              sec_tick,
    input  logic              irq_en,
    input  logic [BYTE_W-1:0] now_sec,
    input  logic [BYTE_W-1:0] now_min,
    input  logic [BYTE_W-1:0] now_hour,
    input  logic [BYTE_W-1:0] now_date,
    output logic              alarm_irq
);
    localparam int FLAG_BIT = BYTE_W - 1;

    typedef struct packed {
        field_arr_t alm;
        logic       irq;
    } state_t;

    state_t st_d, st_q;

    logic [NFIELD-1:0] ok_d;
    logic [NFIELD-1:0] flag_d;
    field_arr_t        now_d;
    rate_e             rate_d;
    logic              hit_d;

    genvar gf;
    generate
        for (gf = 0; gf < NFIELD; gf++) begin : g_fld
            alarm_field_check #(.FIELD(gf)) u_chk (
                .value_i (wr_data),
                .ok_o    (ok_d[gf])
            );
            assign flag_d[gf] = st_q.alm[gf][FLAG_BIT];
        end
    endgenerate

    assign now_d[FLD_SEC]  = now_sec;
    assign now_d[FLD_MIN]  = now_min;
    assign now_d[FLD_HOUR] = now_hour;
    assign now_d[FLD_DATE] = now_date;

    alarm_rate_decode u_rate (
        .flag_i (flag_d),
        .rate_o (rate_d)
    );

    alarm_match u_match (
        .alarm_i (st_q.alm),
        .now_i   (now_d),
        .rate_i  (rate_d),
        .hit_o   (hit_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = sec_tick & irq_en & hit_d;
        if (wr_en && ok_d[reg_sel]) begin
            st_d.alm[reg_sel] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = st_q.alm[reg_sel];
    assign alarm_irq = st_q.irq;

    // A pulse can only follow an enabled tick
    assert_pulse_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> $past(sec_tick && irq_en));

    // Disabled interrupt never pulses
    assert_no_irq_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !alarm_irq);

    // Out-of-range seconds write leaves the register unchanged
    assert_sec_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_W'(FLD_SEC) && bcd_weight(wr_data & 8'h7F) > 8'd59)
        |=> $stable(st_q.alm[FLD_SEC]));

    // Zero date write leaves the register unchanged
    assert_date_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_W'(FLD_DATE) && wr_data[4:0] == 5'd0)
        |=> $stable(st_q.alm[FLD_DATE]));

    // Hours write over 23 leaves the register unchanged
    assert_hour_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_W'(FLD_HOUR) && bcd_weight(wr_data & 8'h3F) > 8'd23)
        |=> $stable(st_q.alm[FLD_HOUR]));
endmodule

// File: tb/tb_bcd_alarm_unit.sv
module tb_bcd_alarm_unit;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [1:0] reg_sel = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       sec_tick = 0;
    logic       irq_en = 1;
    logic [7:0] now_sec = 0, now_min = 0, now_hour = 0, now_date = 0;
    logic       alarm_irq;

    int checks = 0;
    int fails  = 0;

    bcd_alarm_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .sec_tick(sec_tick),
        .irq_en(irq_en), .now_sec(now_sec), .now_min(now_min),
        .now_hour(now_hour), .now_date(now_date), .alarm_irq(alarm_irq)
    );

    always #10 clk = ~clk;

    // Behavioural reference model
    int  m_alm [4];
    bit  m_irq;

    function automatic int wgt(int v);
        return ((v >> 4) & 15) * 10 + (v & 15);
    endfunction

    function automatic bit accept(int sel, int v);
        if (sel <= 1) return wgt(v & 'h7F) <= 59;
        if (sel == 2) return wgt(v & 'h3F) <= 23;
        return wgt(v & 'h1F) != 0;
    endfunction

    function automatic bit model_hit();
        bit s, m, h, d;
        bit fs, fm, fh, fd;
        s = (m_alm[0] & 'h7F) == (now_sec & 'h7F);
        m = (m_alm[1] & 'h7F) == (now_min & 'h7F);
        h = (m_alm[2] & 'h3F) == (now_hour & 'h3F);
        d = (m_alm[3] & 'h3F) == (now_date & 'h3F);
        fs = m_alm[0][7]; fm = m_alm[1][7]; fh = m_alm[2][7]; fd = m_alm[3][7];
        if (!fd && !fh && !fm && !fs) return s && m && h && d;
        if (fd && !fh && !fm && !fs) return s && m && h;
        if (fd && fh && !fm && !fs) return s && m;
        if (fd && fh && fm && !fs) return s;
        return 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_alm[i]) m_alm[i] = 0;
            m_irq = 0;
        end else begin
            m_irq = sec_tick && irq_en && model_hit();
            if (wr_en && accept(reg_sel, wr_data)) m_alm[reg_sel] = wr_data;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R10)
    always @(negedge clk) begin
        if (rst_n) check(alarm_irq == m_irq, "R10 per-cycle", alarm_irq, m_irq);
    end

    task automatic wr(int sel, int v);
        @(negedge clk);
        wr_en = 1; reg_sel = sel[1:0]; wr_data = v[7:0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(int sel, int exp, string req);
        @(negedge clk);
        reg_sel = sel[1:0];
        #1;
        check(rd_data == exp[7:0], req, rd_data, exp);
    endtask

    task automatic tick(int s, int m, int h, int d, bit exp, string req);
        @(negedge clk);
        now_sec = s[7:0]; now_min = m[7:0]; now_hour = h[7:0]; now_date = d[7:0];
        sec_tick = 1;
        @(negedge clk);
        sec_tick = 0;
        check(alarm_irq == exp, req, alarm_irq, exp);
        @(negedge clk);
        check(alarm_irq == 0, "R10 width", alarm_irq, 0);
    endtask

    task automatic set_all(int s, int m, int h, int d);
        wr(0, s); wr(1, m); wr(2, h); wr(3, d);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check(alarm_irq == 0, "R1 irq", alarm_irq, 0);
                rst_n = 1;
                for (int i = 0; i < 4; i++) rd_chk(i, 0, "R1 reset read");

                // Range checks
                wr(0, 'h59); rd_chk(0, 'h59, "R4 sec 59 accepted");
                wr(0, 'h5A); rd_chk(0, 'h59, "R4 sec 0x5A rejected");
                wr(0, 'h1F); rd_chk(0, 'h1F, "R3 nibble F accepted");
                wr(1, 'h60); rd_chk(1, 'h00, "R4 min 60 rejected");
                wr(1, 'hB0); rd_chk(1, 'hB0, "R2 flag bit kept");
                wr(2, 'h24); rd_chk(2, 'h00, "R5 hour 24 rejected");
                wr(2, 'h23); rd_chk(2, 'h23, "R5 hour 23 accepted");
                wr(3, 'h00); rd_chk(3, 'h00, "R6 date 0 rejected");
                wr(3, 'h31); rd_chk(3, 'h31, "R6 date 31 accepted");
                wr(3, 'h20); rd_chk(3, 'h31, "R6 date 0x20 rejected");

                // Monthly
                set_all('h30, 'h15, 'h12, 'h07);
                tick('h30, 'h15, 'h12, 'h07, 1, "R7 monthly match");
                tick('h30, 'h15, 'h12, 'h08, 0, "R7 date differs");
                tick('h31, 'h15, 'h12, 'h07, 0, "R7 sec differs");
                // Daily
                wr(3, 'h87);
                tick('h30, 'h15, 'h12, 'h09, 1, "R8 daily");
                tick('h30, 'h16, 'h12, 'h09, 0, "R8 daily miss");
                // Hourly
                wr(2, 'h92);
                tick('h30, 'h15, 'h03, 'h01, 1, "R8 hourly");
                tick('h29, 'h15, 'h03, 'h01, 0, "R8 hourly miss");
                // Minute
                wr(1, 'h95);
                tick('h30, 'h44, 'h03, 'h01, 1, "R8 minute");
                tick('h31, 'h44, 'h03, 'h01, 0, "R8 minute miss");
                // Every second: all four
                wr(0, 'hB0);
                tick('h01, 'h02, 'h03, 'h04, 1, "R9 all flags");
                // Only seconds flag
                set_all('h80, 'h00, 'h00, 'h01);
                tick('h11, 'h22, 'h05, 'h09, 1, "R9 sec flag only");
                // Enable gating
                irq_en = 0;
                tick('h11, 'h22, 'h05, 'h09, 0, "R11 disabled");
                irq_en = 1;
                // Write and tick on the same edge: old value used
                set_all('h10, 'h20, 'h05, 'h02);
                @(negedge clk);
                now_sec = 'h10; now_min = 'h20; now_hour = 'h05; now_date = 'h02;
                sec_tick = 1; wr_en = 1; reg_sel = 0; wr_data = 'h11;
                @(negedge clk);
                sec_tick = 0; wr_en = 0;
                check(alarm_irq == 1, "R10 old value compared", alarm_irq, 1);
                rd_chk(0, 'h11, "R2 same-edge write stored");
                repeat (3) @(negedge clk);
            end
            begin
                repeat (20000) @(posedge clk);
                check(0, "watchdog", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule